// File: doc/BRIEF.md
# Configuration Start Sequencer

This block is the control state machine that starts the configuration of a programmable device. It watches three reset sources: release of the power-on reset, an active-low program request pin and a one-cycle JTAG reset strobe. It drives and senses the shared open-drain init line. The line is modelled as a drive-low output (`initDrvLow`) and a sensed-level input (`initSense`). The line stays low while the configuration logic is being cleared. It is released once the clear phase is over and the program request is high. A device outside the block may keep the line low to postpone configuration.

The sensed rising edge of the init line does two things at once. It latches the three mode pins, plus the D0 level for the flash read command, and it starts loading. A reserved mode code leads to an error state. During loading, a CRC error pulls the init line low again and keeps it low until a new request restarts the sequence. A clean load-done handshake ends in user mode with `cfgDone` high. While boundary scan owns the pins, the sequencer drives nothing and holds its state.

Top module: `cfg_start_seq`

## Requirements
- R1: After `rstN` is released, `initDrvLow` is 1 while `cfgBusy` and `cfgDone` are 0, and the sequence runs on its own.
- R2: A low level on `progReqN` (after two-flop synchronization) or a `jtagRstStb` pulse, in any state including user mode, asserts `initDrvLow` and clears `cfgDone` within 4 cycles.
- R3: `initDrvLow` stays 1 for as long as `progReqN` is low. After `progReqN` returns high, it is released after `INIT_CYCLES` clock cycles (plus synchronizer latency).
- R4: While `initSense` is held low from outside after release, `cfgBusy` stays 0 and `initDrvLow` stays 0. Loading starts after the sensed rising edge.
- R5: The mode pins and `d0Level` are captured only at the sensed rising edge of the init line. Later changes on these pins leave `cfgMode` and `readOpcode` unchanged.
- R6: Mode decode is: `modePins` 000 gives `cfgMode`=0 (SPI), 010 gives 1 (SPI multi-boot), 101 gives 2 (slave serial), 111 gives 3 (slave parallel). Codes 001, 011, 100 and 110 are reserved. A reserved code gives `modeValid`=0, `cfgBusy`=0 and `initDrvLow`=1 until a new request.
- R7: In both SPI modes, `d0Level`=1 gives `readOpcode`=0x03 and `d0Level`=0 gives 0x0B. In the other modes and for reserved codes, `readOpcode` is 0x00.
- R8: A `crcErr` pulse during loading sets `initDrvLow`=1 and `cfgBusy`=0 from the next cycle. The error is held until the next configuration begins, and it is cleared then.
- R9: `loadDone` without `crcErr` during loading sets `cfgDone`=1 and `cfgBusy`=0. If both arrive in the same cycle, the CRC error wins.
- R10: While `scanActive` is 1, `initDrvLow` is 0, and the sequencer state and its response to requests are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| progReqN | input | 1 | Program request, active low, asynchronous |
| jtagRstStb | input | 1 | One-cycle JTAG reset instruction strobe |
| scanActive | input | 1 | Boundary scan owns the pins |
| initSense | input | 1 | Sensed level of the open-drain init line |
| modePins | input | 3 | Configuration mode pins |
| d0Level | input | 1 | Level on data pin D0 (SPI read command choice) |
| crcErr | input | 1 | CRC error pulse from the loader |
| loadDone | input | 1 | Load complete pulse from the loader |
| initDrvLow | output | 1 | Pull the init line low |
| cfgBusy | output | 1 | Loading in progress |
| cfgDone | output | 1 | Configuration done, user mode |
| modeValid | output | 1 | A non-reserved mode has been captured |
| cfgMode | output | 2 | Captured configuration port |
| readOpcode | output | 8 | Flash read command for SPI modes |

## Verification
During loading, the CRC error path and the load-done path can both fire in the same cycle. A program request can also arrive on the cycle that ends a load. The bench raises `crcErr` and `loadDone` on the same clock edge. It expects the error outcome: the init line is pulled low and `cfgDone` stays 0. A separate test ends a load and then issues a request and a JTAG strobe from user mode. It checks that `cfgDone` falls and the init line goes low.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT_CLR = 3'd0,
    ST_WAIT_REL = 3'd1,
    ST_LOAD     = 3'd2,
    ST_CRC_ERR  = 3'd3,
    ST_MODE_ERR = 3'd4,
    ST_USER     = 3'd5
  } seqStateT;

  typedef enum logic [1:0] {
    PORT_SPI    = 2'd0,
    PORT_SPI_MB = 2'd1,
    PORT_SER    = 2'd2,
    PORT_PAR    = 2'd3
  } cfgPortT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic captureMode;
    logic clrMode;
  } seqStrobeT;

  localparam logic [7:0] OP_NORMAL = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_NONE   = 8'h00;

  function automatic logic modeIsReserved(input logic [2:0] pins);
    case (pins)
      3'b000, 3'b010, 3'b101, 3'b111: modeIsReserved = 1'b0;
      default:                        modeIsReserved = 1'b1;
    endcase
  endfunction

  function automatic cfgPortT modeToPort(input logic [2:0] pins);
    case (pins)
      3'b010:  modeToPort = PORT_SPI_MB;
      3'b101:  modeToPort = PORT_SER;
      3'b111:  modeToPort = PORT_PAR;
      default: modeToPort = PORT_SPI;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_sync.sv
module cfg_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else       chain[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfg_seq_dp.sv
module cfg_seq_dp
  import cfg_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progReqN,
  input  logic       initSense,
  input  logic [2:0] modePins,
  input  logic       d0Level,
  input  seqStrobeT  strobe,
  output logic       progLow,
  output logic       initRise,
  output logic       cntDone,
  output logic       modeReserved,
  output logic       modeValid,
  output logic [1:0] cfgMode,
  output logic [7:0] readOpcode
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

  logic progSync, initSync, initPrev;
  logic [CNT_W-1:0] clrCnt;
  cfgPortT modeReg;
  logic [7:0] opReg;
  logic validReg;

  cfg_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) progSync_i (
    .clk(clk), .rstN(rstN), .din(progReqN), .dout(progSync));

  cfg_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) initSync_i (
    .clk(clk), .rstN(rstN), .din(initSense), .dout(initSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initPrev <= 1'b0;
    else       initPrev <= initSync;
  end

  assign progLow  = ~progSync;
  assign initRise = initSync & ~initPrev;

  // clear-phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   clrCnt <= '0;
    else if (strobe.clrCnt)                      clrCnt <= '0;
    else if (strobe.incCnt && clrCnt != CNT_LAST) clrCnt <= clrCnt + 1'b1;
  end
  assign cntDone = (clrCnt == CNT_LAST);

  assign modeReserved = modeIsReserved(modePins);

  // mode / opcode capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= PORT_SPI;
      opReg    <= OP_NONE;
      validReg <= 1'b0;
    end else if (strobe.clrMode) begin
      modeReg  <= PORT_SPI;
      opReg    <= OP_NONE;
      validReg <= 1'b0;
    end else if (strobe.captureMode) begin
      modeReg  <= modeToPort(modePins);
      validReg <= ~modeReserved;
      if (!modeReserved && (modeToPort(modePins) == PORT_SPI ||
                            modeToPort(modePins) == PORT_SPI_MB))
        opReg <= d0Level ? OP_NORMAL : OP_FAST;
      else
        opReg <= OP_NONE;
    end
  end

  assign modeValid  = validReg;
  assign cfgMode    = modeReg;
  assign readOpcode = opReg;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt <= CNT_LAST); // R3
  AST_MODE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validReg) |-> $past(initRise)); // R5
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.captureMode && !strobe.clrMode) |=> $stable(modeReg) && $stable(opReg)); // R5
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      scanActive,
  input  logic      jtagRstStb,
  input  logic      crcErr,
  input  logic      loadDone,
  input  logic      progLow,
  input  logic      initRise,
  input  logic      cntDone,
  input  logic      modeReserved,
  output seqStrobeT strobe,
  output logic      drvLow,
  output logic      cfgBusy,
  output logic      cfgDone
);
  seqStateT state, stateNxt;
  logic restart;

  assign restart = progLow | jtagRstStb;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (scanActive) begin
      stateNxt = state;
    end else if (restart) begin
      stateNxt       = ST_INIT_CLR;
      strobe.clrCnt  = 1'b1;
      strobe.clrMode = 1'b1;
    end else begin
      case (state)
        ST_INIT_CLR: begin
          if (cntDone) stateNxt = ST_WAIT_REL;
          else         strobe.incCnt = 1'b1;
        end
        ST_WAIT_REL: begin
          if (initRise) begin
            strobe.captureMode = 1'b1;
            stateNxt = modeReserved ? ST_MODE_ERR : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (crcErr)        stateNxt = ST_CRC_ERR;
          else if (loadDone) stateNxt = ST_USER;
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT_CLR;
    else       state <= stateNxt;
  end

  assign drvLow  = (state == ST_INIT_CLR) || (state == ST_CRC_ERR) || (state == ST_MODE_ERR);
  assign cfgBusy = (state == ST_LOAD);
  assign cfgDone = (state == ST_USER);

  AST_PROG_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (progLow && !scanActive) |=> drvLow); // R3
  AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REL && !initRise) |=> !cfgBusy); // R4
  AST_RSV_TO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REL && initRise && modeReserved && !restart && !scanActive)
      |=> (drvLow && !cfgBusy)); // R6
  AST_CRC_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusy && crcErr && !restart && !scanActive) |=> (drvLow && !cfgDone)); // R9
  AST_SCAN_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    scanActive |=> $stable(state)); // R10
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && (drvLow || cfgBusy))); // R9
endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq
  import cfg_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progReqN,
  input  logic       jtagRstStb,
  input  logic       scanActive,
  input  logic       initSense,
  input  logic [2:0] modePins,
  input  logic       d0Level,
  input  logic       crcErr,
  input  logic       loadDone,
  output logic       initDrvLow,
  output logic       cfgBusy,
  output logic       cfgDone,
  output logic       modeValid,
  output logic [1:0] cfgMode,
  output logic [7:0] readOpcode
);
  seqStrobeT strobe;
  logic progLow, initRise, cntDone, modeReserved, drvLow;

  cfg_seq_dp #(.INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .progReqN(progReqN), .initSense(initSense),
    .modePins(modePins), .d0Level(d0Level), .strobe(strobe),
    .progLow(progLow), .initRise(initRise), .cntDone(cntDone),
    .modeReserved(modeReserved), .modeValid(modeValid),
    .cfgMode(cfgMode), .readOpcode(readOpcode));

  cfg_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .scanActive(scanActive), .jtagRstStb(jtagRstStb),
    .crcErr(crcErr), .loadDone(loadDone), .progLow(progLow),
    .initRise(initRise), .cntDone(cntDone), .modeReserved(modeReserved),
    .strobe(strobe), .drvLow(drvLow), .cfgBusy(cfgBusy), .cfgDone(cfgDone));

  // boundary scan owns the pin: sequencer drive is masked
  assign initDrvLow = drvLow & ~scanActive;

  AST_SCAN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (scanActive && drvLow) |-> !initDrvLow); // R10
endmodule

// File: tb/cfg_start_seq_tb.sv
module cfg_start_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progReqN = 1'b1;
  logic jtagRstStb = 1'b0;
  logic scanActive = 1'b0;
  logic extHold = 1'b0;
  logic [2:0] modePins = 3'b101;
  logic d0Level = 1'b1;
  logic crcErr = 1'b0;
  logic loadDone = 1'b0;
  logic initSense;
  logic initDrvLow, cfgBusy, cfgDone, modeValid;
  logic [1:0] cfgMode;
  logic [7:0] readOpcode;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk; // 50 MHz

  // open-drain line with external pull-up
  assign initSense = ~initDrvLow & ~extHold;

  cfg_start_seq dut_i (
    .clk(clk), .rstN(rstN), .progReqN(progReqN), .jtagRstStb(jtagRstStb),
    .scanActive(scanActive), .initSense(initSense), .modePins(modePins),
    .d0Level(d0Level), .crcErr(crcErr), .loadDone(loadDone),
    .initDrvLow(initDrvLow), .cfgBusy(cfgBusy), .cfgDone(cfgDone),
    .modeValid(modeValid), .cfgMode(cfgMode), .readOpcode(readOpcode));

  typedef struct packed {
    logic [2:0] pins;
    logic       d0;
    logic       ok;
    logic [1:0] mode;
    logic [7:0] op;
  } vecT;

  localparam int NVEC = 12;
  localparam vecT VECS [NVEC] = '{
    '{3'b000, 1'b1, 1'b1, 2'd0, 8'h03},
    '{3'b000, 1'b0, 1'b1, 2'd0, 8'h0B},
    '{3'b010, 1'b1, 1'b1, 2'd1, 8'h03},
    '{3'b010, 1'b0, 1'b1, 2'd1, 8'h0B},
    '{3'b101, 1'b1, 1'b1, 2'd2, 8'h00},
    '{3'b101, 1'b0, 1'b1, 2'd2, 8'h00},
    '{3'b111, 1'b0, 1'b1, 2'd3, 8'h00},
    '{3'b111, 1'b1, 1'b1, 2'd3, 8'h00},
    '{3'b001, 1'b1, 1'b0, 2'd0, 8'h00},
    '{3'b011, 1'b0, 1'b0, 2'd0, 8'h00},
    '{3'b100, 1'b1, 1'b0, 2'd0, 8'h00},
    '{3'b110, 1'b0, 1'b0, 2'd0, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic progPulse();
    progReqN = 1'b0;
    tick(6);
    progReqN = 1'b1;
    tick(40);
  endtask

  task automatic finishLoad();
    loadDone = 1'b1;
    tick(1);
    loadDone = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset state and autonomous start
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R1 drvLow", initDrvLow, 1);
    check("R1 busy", cfgBusy, 0);
    check("R1 done", cfgDone, 0);
    tick(40);
    check("R1 auto start busy", cfgBusy, 1);
    check("R6 auto mode serial", cfgMode, 2);

    // table: mode decode and opcode choice (R6, R7)
    for (int i = 0; i < NVEC; i++) begin
      modePins = VECS[i].pins;
      d0Level  = VECS[i].d0;
      progPulse();
      check("R6 modeValid", modeValid, VECS[i].ok);
      check("R7 opcode", readOpcode, VECS[i].op);
      if (VECS[i].ok) begin
        check("R6 cfgMode", cfgMode, VECS[i].mode);
        check("R6 busy", cfgBusy, 1);
        finishLoad();
        check("R9 done", cfgDone, 1);
        check("R9 busy off", cfgBusy, 0);
      end else begin
        check("R6 reserved drv", initDrvLow, 1);
        check("R6 reserved busy", cfgBusy, 0);
        tick(30);
        check("R6 reserved held", initDrvLow, 1);
      end
    end

    // R2: program request from user mode
    modePins = 3'b000; d0Level = 1'b1;
    progPulse();
    finishLoad();
    check("R2 user before", cfgDone, 1);
    progReqN = 1'b0;
    tick(4);
    check("R2 prog drv", initDrvLow, 1);
    check("R2 prog done", cfgDone, 0);

    // R3: held while request low, released after clear phase
    tick(40);
    check("R3 held low", initDrvLow, 1);
    progReqN = 1'b1;
    tick(10);
    check("R3 still clearing", initDrvLow, 1);
    tick(20);
    check("R3 released", initDrvLow, 0);
    tick(10);
    finishLoad();

    // R2: JTAG reset strobe from user mode
    jtagRstStb = 1'b1;
    tick(1);
    jtagRstStb = 1'b0;
    check("R2 jtag drv", initDrvLow, 1);
    check("R2 jtag done", cfgDone, 0);
    tick(40);

    // R4: external hold delays start
    progReqN = 1'b0; extHold = 1'b1;
    tick(6);
    progReqN = 1'b1;
    tick(60);
    check("R4 held busy", cfgBusy, 0);
    check("R4 held drv", initDrvLow, 0);
    extHold = 1'b0;
    tick(10);
    check("R4 start after hold", cfgBusy, 1);

    // R5: pins ignored after capture
    modePins = 3'b111; d0Level = 1'b0;
    progPulse();
    check("R5 captured", cfgMode, 3);
    modePins = 3'b000; d0Level = 1'b1;
    tick(5);
    check("R5 mode kept", cfgMode, 3);
    check("R5 opcode kept", readOpcode, 8'h00);

    // R8: CRC error flag and clearing
    progPulse();
    check("R8 spi busy", cfgBusy, 1);
    crcErr = 1'b1;
    tick(1);
    crcErr = 1'b0;
    check("R8 crc drv", initDrvLow, 1);
    check("R8 crc busy", cfgBusy, 0);
    tick(20);
    check("R8 crc held", initDrvLow, 1);
    check("R8 crc no done", cfgDone, 0);
    progPulse();
    check("R8 cleared drv", initDrvLow, 0);
    check("R8 cleared busy", cfgBusy, 1);

    // R9: CRC error and load done in the same cycle
    crcErr = 1'b1; loadDone = 1'b1;
    tick(1);
    crcErr = 1'b0; loadDone = 1'b0;
    tick(1);
    check("R9 tie done", cfgDone, 0);
    check("R9 tie drv", initDrvLow, 1);

    // R10: scan control masks drive and freezes state
    modePins = 3'b100;
    progPulse();
    check("R10 pre error", initDrvLow, 1);
    scanActive = 1'b1;
    tick(1);
    check("R10 drive masked", initDrvLow, 0);
    modePins = 3'b000;
    progReqN = 1'b0;
    tick(6);
    progReqN = 1'b1;
    tick(40);
    check("R10 still masked", initDrvLow, 0);
    scanActive = 1'b0;
    tick(2);
    check("R10 frozen drv", initDrvLow, 1);
    tick(30);
    check("R10 frozen busy", cfgBusy, 0);
    check("R10 frozen valid", modeValid, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule